// File: doc/BRIEF.md
# Asynchronous Character Transmitter with Break

This block takes parallel characters from a host and sends them on a single serial line as asynchronous frames. A frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop interval of 1, 1.5 or 2 bit times. The line rests high between frames. The module clock is the transmit clock, and one bit lasts 1, 16 or 64 of its cycles. The frame settings are captured when a character enters the shifter, so they can change while that character is being sent.

A holding register and a shift register form a double buffer. The host can load the next character while the current one is going out. A ready output tells the host that the holding register can accept a write. An empty output tells it that the holding register and the shifter are both idle. A new frame starts only while the transmit-enable control and the clear-to-send input are both high. If clear-to-send drops during a frame, that frame still finishes. A break control holds the line low for as long as it is asserted. The frame timing keeps running underneath the break.

Top module: `serial_tx_brk`

## Requirements
- R1: A frame is one start bit at 0, then the data bits with bit 0 first, then the stop interval at 1. The data length is `cfg_len`+5 bits (0 gives 5 bits, 3 gives 8 bits). The line is 1 when no frame is running.
- R2: When `cfg_par_en`=1, a parity bit follows the last data bit. With `cfg_par_odd`=0 the data bits plus the parity bit hold an even number of ones. With `cfg_par_odd`=1 they hold an odd number.
- R3: Each start, data and parity bit lasts 1 clock when `cfg_rate`=0, 16 clocks when `cfg_rate`=1, and 64 clocks when `cfg_rate` is 2 or 3.
- R4: `cfg_stop`=0 gives a stop interval of 1 bit time and `cfg_stop` of 2 or 3 gives 2 bit times. `cfg_stop`=1 gives 1.5 bit times, which is 24 clocks at 16x and 96 clocks at 64x. At 1x, `cfg_stop`=1 gives 2 clocks.
- R5: `rdy` is high exactly when the holding register is free and `tx_en` and `cts` are both high. It is low in the cycle after an accepted write. It is high again in the cycle after that character moves into the shifter.
- R6: `empty` is high only when the holding register is free and no frame is running. It rises in the cycle after the last stop clock.
- R7: A held character moves into the shifter at the first clock edge where `tx_en` and `cts` are both high and the shifter is idle or is in its last stop clock. The start bit appears on `txd` after that edge. Consecutive frames therefore have no idle clocks between them.
- R8: If `cts` drops during a frame, that frame completes unchanged. No further frame starts until `cts` returns.
- R9: A write while the holding register is full and no transfer happens at that edge is ignored. The held character is kept.
- R10: A write at the same edge where the held character moves into the shifter is accepted. That character is sent as the next frame.
- R11: `txd` is 0 from the cycle after `brk` is sampled high until the cycle after `brk` is sampled low. The frame timing keeps running during the break, so `txd` returns to the level of the frame in progress.
- R12: After reset, `txd` is 1, `empty` is 1 and the holding register is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, 1, 16 or 64 cycles per bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rate | input | 2 | Clocks per bit: 0 is 1, 1 is 16, 2 or 3 is 64 |
| cfg_len | input | 2 | Data length minus 5 |
| cfg_par_en | input | 1 | Add a parity bit |
| cfg_par_odd | input | 1 | Odd parity when 1, even parity when 0 |
| cfg_stop | input | 2 | Stop interval: 0 is 1 bit, 1 is 1.5 bits, 2 or 3 is 2 bits |
| tx_en | input | 1 | Transmit enable |
| cts | input | 1 | Clear to send, active high |
| brk | input | 1 | Force the line low |
| wr_stb | input | 1 | Host write strobe, one cycle |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Registered serial output |
| rdy | output | 1 | Holding register can take a character |
| empty | output | 1 | Holding register and shifter both idle |

## Verification
A host write and the transfer of the held character into the shifter can happen on the same clock edge. That edge is the last stop clock of a frame, while a character is already waiting. The bench provokes this by queueing one character during a frame and then writing a second one in exactly the final stop cycle. It judges the result by decoding the next two frames on `txd` clock by clock: both characters must appear in order with no idle clock between them. A write earlier in the same frame must be dropped.

// File: rtl/serial_tx_brk.sv
module serial_tx_brk #(
  parameter int MAX_BITS = 8,
  parameter int MID_DIV  = 16,
  parameter int FAST_DIV = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg_rate,
  input  logic [1:0]          cfg_len,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic [1:0]          cfg_stop,
  input  logic                tx_en,
  input  logic                cts,
  input  logic                brk,
  input  logic                wr_stb,
  input  logic [MAX_BITS-1:0] wr_data,
  output logic                txd,
  output logic                rdy,
  output logic                empty
);
  localparam int CW = $clog2(2 * FAST_DIV) + 1;
  localparam int BW = $clog2(MAX_BITS);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t                st, nst;
  logic [CW-1:0]      cnt, ncnt;
  logic [MAX_BITS-1:0] sh, nsh, hold, mask;
  logic [BW-1:0]      bl, nbl;
  logic               par_q, npar, hold_full, txd_q, lvl, busy;
  logic [1:0]         rate_q, len_q, stop_q;
  logic               pen_q;

  function automatic logic [CW-1:0] bit_len(input logic [1:0] r);
    return (r == 2'd0) ? CW'(1) : (r == 2'd1) ? CW'(MID_DIV) : CW'(FAST_DIV);
  endfunction

  function automatic logic [CW-1:0] stop_len(input logic [1:0] r, input logic [1:0] s);
    logic [CW-1:0] b;
    b = bit_len(r);
    if (r == 2'd0) return (s == 2'd0) ? CW'(1) : CW'(2);
    case (s)
      2'd0:    return b;
      2'd1:    return b + (b >> 1);
      default: return b << 1;
    endcase
  endfunction

  wire            cnt_zero = (cnt == '0);
  wire            go       = hold_full && tx_en && cts;
  wire            fin      = (st == S_STOP) && cnt_zero;
  wire            load     = go && ((st == S_IDLE) || fin);
  wire [CW-1:0]   dq       = bit_len(rate_q);
  wire [CW-1:0]   sq       = stop_len(rate_q, stop_q);

  always_comb
    for (int i = 0; i < MAX_BITS; i++)
      mask[i] = (i < MAX_BITS - 3 + int'(cfg_len));

  always_comb begin
    nst  = st;
    ncnt = cnt;
    nsh  = sh;
    nbl  = bl;
    npar = par_q;
    if (load) begin
      nst  = S_START;
      ncnt = bit_len(cfg_rate) - CW'(1);
      nsh  = hold;
      npar = cfg_par_odd ^ (^(hold & mask));
    end else if (st != S_IDLE) begin
      if (!cnt_zero) ncnt = cnt - CW'(1);
      else begin
        case (st)
          S_START: begin
            nst  = S_DATA;
            ncnt = dq - CW'(1);
            nbl  = BW'(MAX_BITS - 4) + BW'(len_q);
          end
          S_DATA: begin
            if (bl == '0) begin
              nst  = pen_q ? S_PAR : S_STOP;
              ncnt = pen_q ? dq - CW'(1) : sq - CW'(1);
            end else begin
              nsh  = sh >> 1;
              nbl  = bl - BW'(1);
              ncnt = dq - CW'(1);
            end
          end
          S_PAR: begin
            nst  = S_STOP;
            ncnt = sq - CW'(1);
          end
          default: nst = S_IDLE;
        endcase
      end
    end
  end

  always_comb
    case (nst)
      S_START: lvl = 1'b0;
      S_DATA:  lvl = nsh[0];
      S_PAR:   lvl = npar;
      default: lvl = 1'b1;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      sh     <= '0;
      bl     <= '0;
      par_q  <= 1'b0;
      rate_q <= '0;
      len_q  <= '0;
      stop_q <= '0;
      pen_q  <= 1'b0;
      txd_q  <= 1'b1;
    end else begin
      st    <= nst;
      cnt   <= ncnt;
      sh    <= nsh;
      bl    <= nbl;
      par_q <= npar;
      txd_q <= brk ? 1'b0 : lvl;
      if (load) begin
        rate_q <= cfg_rate;
        len_q  <= cfg_len;
        stop_q <= cfg_stop;
        pen_q  <= cfg_par_en;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold      <= '0;
      hold_full <= 1'b0;
    end else if (wr_stb && (!hold_full || load)) begin
      hold      <= wr_data;
      hold_full <= 1'b1;
    end else if (load) begin
      hold_full <= 1'b0;
    end

  assign busy  = (st != S_IDLE);
  assign txd   = txd_q;
  assign rdy   = !hold_full && tx_en && cts;
  assign empty = !hold_full && !busy;
endmodule

// File: rtl/serial_tx_brk_chk.sv
module serial_tx_brk_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic cts,
  input logic brk,
  input logic wr_stb,
  input logic txd,
  input logic rdy,
  input logic empty,
  input logic busy
);
  a_r11_brk_low: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> !txd);

  a_r5_rdy_gated: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> (tx_en && cts));

  a_r5_write_drops_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && rdy) |=> !rdy);

  a_r7_no_start_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(tx_en && cts)) |=> !busy);

  a_r6_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !$past(brk)) |-> txd);

  a_r6_busy_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !empty);
endmodule

bind serial_tx_brk serial_tx_brk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cts(cts), .brk(brk),
  .wr_stb(wr_stb), .txd(txd), .rdy(rdy), .empty(empty), .busy(busy)
);

// File: tb/tb_serial_tx_brk.sv
`timescale 1ns/1ps
module tb_serial_tx_brk;
  logic clk = 0, rst_n = 0;
  logic [1:0] c_rate = 0, c_len = 0, c_stop = 0;
  logic c_pen = 0, c_odd = 0;
  logic tx_en = 0, cts = 0, brk = 0, wr_stb = 0;
  logic [7:0] wr_data = 0;
  logic txd, rdy, empty;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  serial_tx_brk dut (
    .clk(clk), .rst_n(rst_n), .cfg_rate(c_rate), .cfg_len(c_len),
    .cfg_par_en(c_pen), .cfg_par_odd(c_odd), .cfg_stop(c_stop),
    .tx_en(tx_en), .cts(cts), .brk(brk), .wr_stb(wr_stb), .wr_data(wr_data),
    .txd(txd), .rdy(rdy), .empty(empty)
  );

  function automatic int f_d();
    return (c_rate == 0) ? 1 : (c_rate == 1) ? 16 : 64;
  endfunction
  function automatic int f_stop();
    int d = f_d();
    if (c_rate == 0) return (c_stop == 0) ? 1 : 2;
    return (c_stop == 0) ? d : (c_stop == 1) ? d * 3 / 2 : 2 * d;
  endfunction
  function automatic int f_n();
    return 5 + int'(c_len);
  endfunction
  function automatic int f_frame();
    return f_d() * (1 + f_n() + int'(c_pen)) + f_stop();
  endfunction
  function automatic logic f_lvl(input logic [7:0] d, input int t);
    int dd = f_d(), idx;
    logic p = c_odd;
    if (t < dd) return 1'b0;
    idx = t / dd - 1;
    if (idx < f_n()) return d[idx];
    for (int i = 0; i < f_n(); i++) p ^= d[i];
    if (c_pen && idx == f_n()) return p;
    return 1'b1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] r, input logic [1:0] l, input logic pe,
                         input logic po, input logic [1:0] s);
    c_rate = r; c_len = l; c_pen = pe; c_odd = po; c_stop = s;
  endtask

  task automatic write_and_wait(input logic [7:0] d);
    wr_stb = 1; wr_data = d;
    @(negedge clk);
    wr_stb = 0;
    chk(rdy == 0 && empty == 0 && txd == 1, "R5 rdy low after write", {rdy, empty, txd}, 3'b001);
    @(negedge clk);
  endtask

  task automatic check_frame(input logic [7:0] d, input int w1, input logic [7:0] v1,
                             input int w2, input logic [7:0] v2, input int coff,
                             input int bon, input int boff, input bit held0, input string tag);
    int L = f_frame();
    bit held = held0;
    bit ok = 1;
    for (int t = 0; t < L; t++) begin
      logic e, er;
      e = f_lvl(d, t);
      if (bon >= 0 && t > bon && t <= boff) e = 1'b0;
      er = !held && cts && tx_en;
      if (ok && (txd !== e || empty !== 1'b0 || rdy !== er)) begin
        ok = 0;
        nfail++;
        $display("FAIL %s t=%0d txd/empty/rdy=%b%b%b expected=%b0%b", tag, t, txd, empty, rdy, e, er);
      end
      wr_stb = 0;
      if (t == w1) begin wr_stb = 1; wr_data = v1; held = 1; end
      if (t == w2) begin wr_stb = 1; wr_data = v2; held = 1; end
      if (t == coff) cts = 0;
      if (t == bon) brk = 1;
      if (t == boff) brk = 0;
      @(negedge clk);
    end
    wr_stb = 0;
    nchk++;
  endtask

  task automatic check_idle(input string tag);
    chk(empty == 1 && txd == 1 && rdy == 1, tag, {empty, txd, rdy}, 3'b111);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    chk(txd == 1 && empty == 1, "R12 reset state", {txd, empty}, 2'b11);
    rst_n = 1;
    @(negedge clk);
    chk(txd == 1 && empty == 1 && rdy == 0, "R12 R5 after reset, disabled", {txd, empty, rdy}, 3'b110);
    tx_en = 1; cts = 1;
    @(negedge clk);
    chk(rdy == 1, "R5 rdy when enabled", rdy, 1);

    // 16x, 8 bits, even parity, 1.5 stop; chained frames, ignored and same-edge writes
    set_cfg(2'd1, 2'd3, 1, 0, 2'd1);
    chk(f_stop() == 24, "R4 bench 1.5 stop 16x", f_stop(), 24);
    write_and_wait(8'hA5);
    check_frame(8'hA5, 2, 8'h3C, 6, 8'hFF, -1, -1, -1, 0, "R1 R2 R4 R9 frame A5");
    check_frame(8'h3C, 3, 8'h81, f_frame() - 1, 8'h42, -1, -1, -1, 0, "R7 R9 frame 3C");
    check_frame(8'h81, -1, 0, -1, 0, -1, -1, -1, 1, "R10 frame 81");
    check_frame(8'h42, -1, 0, -1, 0, -1, -1, -1, 0, "R10 frame 42");
    check_idle("R6 idle after chain");

    // 1x, 7 bits, odd parity, 2 stop; cts drops mid-frame
    set_cfg(2'd0, 2'd2, 1, 1, 2'd2);
    write_and_wait(8'h55);
    check_frame(8'h55, 1, 8'h0F, -1, 0, 3, -1, -1, 0, "R8 frame completes");
    begin
      bit ok = 1;
      for (int i = 0; i < 20; i++) begin
        if (txd !== 1 || empty !== 0 || rdy !== 0) ok = 0;
        @(negedge clk);
      end
      chk(ok, "R8 R7 no start without cts", {txd, empty, rdy}, 3'b100);
    end
    cts = 1;
    @(negedge clk);
    check_frame(8'h0F, -1, 0, -1, 0, -1, -1, -1, 0, "R7 frame after cts");
    check_idle("R6 idle after cts frame");

    // 1x with 1.5 stop treated as 2
    set_cfg(2'd0, 2'd0, 0, 0, 2'd1);
    chk(f_frame() == 8, "R4 bench 1x frame len", f_frame(), 8);
    write_and_wait(8'h1A);
    check_frame(8'h1A, -1, 0, -1, 0, -1, -1, -1, 0, "R4 1x 1.5 stop");
    check_idle("R6 idle 1x");

    // 64x, 8 bits, odd parity, 1.5 stop
    set_cfg(2'd2, 2'd3, 1, 1, 2'd1);
    write_and_wait(8'hC3);
    check_frame(8'hC3, -1, 0, -1, 0, -1, -1, -1, 0, "R3 R4 64x frame");
    check_idle("R6 idle 64x");

    // break during a frame, then during idle
    set_cfg(2'd1, 2'd0, 0, 0, 2'd0);
    write_and_wait(8'h1B);
    check_frame(8'h1B, -1, 0, -1, 0, -1, 10, 40, 0, "R11 break mid-frame");
    check_idle("R11 R6 idle after break");
    brk = 1;
    @(negedge clk);
    begin
      bit ok = 1;
      for (int i = 0; i < 30; i++) begin
        if (txd !== 0 || empty !== 1) ok = 0;
        @(negedge clk);
      end
      chk(ok, "R11 idle break low", {txd, empty}, 2'b01);
    end
    brk = 0;
    @(negedge clk);
    chk(txd == 1, "R11 release restores high", txd, 1);

    // random frames, some chained
    for (int k = 0; k < 40; k++) begin
      int r = $urandom % 8;
      logic [7:0] d1 = 8'($urandom), d2 = 8'($urandom);
      set_cfg((r < 5) ? 2'd1 : (r < 7) ? 2'd0 : 2'd2, 2'($urandom), 1'($urandom),
              1'($urandom), 2'($urandom));
      write_and_wait(d1);
      if ($urandom % 2) begin
        int w = $urandom % (f_frame() - 1);
        check_frame(d1, w, d2, -1, 0, -1, -1, -1, 0, "R1 R2 R3 R4 random chained");
        check_frame(d2, -1, 0, -1, 0, -1, -1, -1, 0, "R7 random second");
      end else begin
        check_frame(d1, -1, 0, -1, 0, -1, -1, -1, 0, "R1 R2 R3 R4 random");
      end
      check_idle("R6 random idle");
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule